// File: doc/BRIEF.md
# Converter Code Offset and Gain Calibration Pipeline

This block takes raw two's-complement samples from a converter front end and produces calibrated output codes. The front end scales every sample to three quarters of its nominal size, so that the corrections applied here cannot push the path into saturation. The block first removes a programmable offset. It then multiplies the result by a programmable gain ratio whose reset value undoes that three-quarter scaling. Finally it forms either a unipolar code, which is doubled, or a bipolar code in offset binary. Results that fall outside the code range are clamped to the nearest end rather than wrapping.

Two coefficient registers hold the offset and the gain. Each resets to a value that applies no correction. They are loaded through a small write port. The datapath has three register stages and accepts one sample on every clock. Each sample carries its own mode flag, so unipolar and bipolar samples can be mixed freely in one stream.

Top module: `adc_cal_core`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is low after that edge, and samples in flight are discarded. The offset register reloads 0x800000 and the gain register reloads 0x555555.
- R2: The offset actually subtracted from the sample equals the offset register minus 0x800000. Each count of the register moves the corrected value by one LSB, before the gain is applied.
- R3: The offset-corrected value is multiplied by the gain register, read as an unsigned number, and divided by 2^22. The division rounds to nearest, and exact halves round toward positive infinity.
- R4: When the sample's `in_bipolar` is 0, the output code is twice the gain-scaled value.
- R5: When the sample's `in_bipolar` is 1, the output code is the gain-scaled value plus 0x800000.
- R6: An output below 0 is forced to 0x000000, and an output above 0xFFFFFF is forced to 0xFFFFFF.
- R7: A sample presented with `in_valid` high at rising edge N shows up on `out_code`, with `out_valid` high, right after edge N+2. Back-to-back samples are accepted and come out in order. `out_code` holds its value in cycles where `out_valid` is low.
- R8: When `cfg_we` is high, `cfg_addr`=0 writes the offset register and `cfg_addr`=1 writes the gain register. A sample accepted at the same edge as a write uses the old value. Samples accepted at later edges use the new value.
- R9: The mode flag is captured together with its sample. Changing `in_bipolar` between samples therefore affects only the samples presented with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 1 | Coefficient select: 0 offset, 1 gain |
| cfg_wdata | input | 24 | Coefficient write value |
| in_valid | input | 1 | Sample present this cycle |
| in_bipolar | input | 1 | Output format for this sample: 0 unipolar, 1 bipolar |
| in_sample | input | 24 | Raw two's-complement sample, pre-scaled to 75 % |
| out_valid | output | 1 | Calibrated result present |
| out_code | output | 24 | Calibrated, clamped output code |

## Verification
The hardest case to reach from the ports is a coefficient write that lands on the same clock edge as an accepted sample, while other samples are still in the pipeline. The bench drives `cfg_we` and `in_valid` in the same cycle. The next sample follows immediately. The bench expects the first sample to be converted with the old coefficient and the second with the new one. A second hard case is a reset that arrives with a sample still in flight. Here the bench checks that the sample never comes out, and that the coefficients written earlier are replaced by their defaults.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int unsigned CAL_DATA_W = 24;
  localparam int unsigned CAL_COEF_W = 24;
  localparam int unsigned CAL_SHIFT  = 22;

  // coefficient select encoding on the write port
  localparam logic CFG_SEL_OFFSET = 1'b0;
  localparam logic CFG_SEL_GAIN   = 1'b1;

  typedef enum logic {
    FMT_UNIPOLAR = 1'b0,
    FMT_BIPOLAR  = 1'b1
  } cal_fmt_e;
endpackage

// File: rtl/adc_cal_coef_regs.sv
module adc_cal_coef_regs
  import adc_cal_pkg::*;
#(
  parameter int unsigned COEF_W = CAL_COEF_W,
  parameter logic [COEF_W-1:0] OFF_RESET  = 24'h800000,
  parameter logic [COEF_W-1:0] GAIN_RESET = 24'h555555
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  output logic [COEF_W-1:0] off_coef,
  output logic [COEF_W-1:0] gain_coef
);
  always_ff @(posedge clk) begin
    if (rst) begin
      off_coef  <= OFF_RESET;
      gain_coef <= GAIN_RESET;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_SEL_OFFSET) off_coef  <= cfg_wdata;
      else                            gain_coef <= cfg_wdata;
    end
  end
endmodule

// File: rtl/adc_cal_offset_stage.sv
module adc_cal_offset_stage #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned COEF_W = 24,
  localparam int unsigned DIFF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_bipolar,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [COEF_W-1:0]        off_coef,
  input  logic [COEF_W-1:0]        gain_coef,
  output logic                     s1_valid,
  output logic                     s1_bipolar,
  output logic signed [DIFF_W-1:0] s1_diff,
  output logic [COEF_W-1:0]        s1_gain
);
  localparam logic signed [DIFF_W-1:0] OFF_BIAS =
    {{(DIFF_W-COEF_W){1'b0}}, 1'b1, {(COEF_W-1){1'b0}}};

  logic signed [DIFF_W-1:0] samp_x;
  logic signed [DIFF_W-1:0] off_x;
  logic signed [DIFF_W-1:0] off_eff;

  always_comb begin
    samp_x  = {{(DIFF_W-DATA_W){in_sample[DATA_W-1]}}, in_sample};
    off_x   = {{(DIFF_W-COEF_W){1'b0}}, off_coef};
    off_eff = off_x - OFF_BIAS;
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  // coefficients and mode travel with the sample so later writes cannot mix in
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_diff    <= samp_x - off_eff;
      s1_gain    <= gain_coef;
      s1_bipolar <= in_bipolar;
    end
  end
endmodule

// File: rtl/adc_cal_gain_stage.sv
module adc_cal_gain_stage #(
  parameter int unsigned DIFF_W = 26,
  parameter int unsigned COEF_W = 24,
  localparam int unsigned PROD_W = DIFF_W + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic                     s1_bipolar,
  input  logic signed [DIFF_W-1:0] s1_diff,
  input  logic [COEF_W-1:0]        s1_gain,
  output logic                     s2_valid,
  output logic                     s2_bipolar,
  output logic signed [PROD_W-1:0] s2_prod
);
  logic signed [PROD_W-1:0] diff_x;
  logic signed [PROD_W-1:0] gain_x;

  always_comb begin
    diff_x = {{(PROD_W-DIFF_W){s1_diff[DIFF_W-1]}}, s1_diff};
    gain_x = {{(PROD_W-COEF_W){1'b0}}, s1_gain};
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_prod    <= diff_x * gain_x;
      s2_bipolar <= s1_bipolar;
    end
  end
endmodule

// File: rtl/adc_cal_output_stage.sv
module adc_cal_output_stage #(
  parameter int unsigned PROD_W = 51,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SHIFT  = 22,
  parameter bit          ROUND_NEAREST = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s2_valid,
  input  logic                     s2_bipolar,
  input  logic signed [PROD_W-1:0] s2_prod,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_code
);
  localparam logic signed [PROD_W-1:0] HALF_LSB =
    {{(PROD_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] MID_CODE =
    {{(PROD_W-DATA_W){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] TOP_CODE =
    {{(PROD_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

  logic signed [PROD_W-1:0] scaled;
  logic signed [PROD_W-1:0] formed;
  logic [DATA_W-1:0]        clamped;

  generate
    if (ROUND_NEAREST) begin : g_round
      always_comb scaled = (s2_prod + HALF_LSB) >>> SHIFT;
    end else begin : g_trunc
      always_comb scaled = s2_prod >>> SHIFT;
    end
  endgenerate

  always_comb begin
    formed = s2_bipolar ? (scaled + MID_CODE) : (scaled <<< 1);
    if (formed[PROD_W-1])       clamped = '0;
    else if (formed > TOP_CODE) clamped = '1;
    else                        clamped = formed[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    if (rst)           out_code <= '0;
    else if (s2_valid) out_code <= clamped;
  end
endmodule

// File: rtl/adc_cal_core.sv
module adc_cal_core
  import adc_cal_pkg::*;
#(
  parameter int unsigned DATA_W = CAL_DATA_W,
  parameter int unsigned COEF_W = CAL_COEF_W,
  parameter int unsigned SHIFT  = CAL_SHIFT,
  parameter bit          ROUND_NEAREST = 1'b1,
  localparam int unsigned DIFF_W = DATA_W + 2,
  localparam int unsigned PROD_W = DIFF_W + COEF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              in_valid,
  input  logic              in_bipolar,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_code
);
  logic [COEF_W-1:0]        off_coef;
  logic [COEF_W-1:0]        gain_coef;
  logic                     s1_valid;
  logic                     s1_bipolar;
  logic signed [DIFF_W-1:0] s1_diff;
  logic [COEF_W-1:0]        s1_gain;
  logic                     s2_valid;
  logic                     s2_bipolar;
  logic signed [PROD_W-1:0] s2_prod;

  adc_cal_coef_regs #(.COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .off_coef(off_coef), .gain_coef(gain_coef)
  );

  adc_cal_offset_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_off (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bipolar(in_bipolar),
    .in_sample(in_sample), .off_coef(off_coef), .gain_coef(gain_coef),
    .s1_valid(s1_valid), .s1_bipolar(s1_bipolar), .s1_diff(s1_diff),
    .s1_gain(s1_gain)
  );

  adc_cal_gain_stage #(.DIFF_W(DIFF_W), .COEF_W(COEF_W)) u_gain (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_bipolar(s1_bipolar),
    .s1_diff(s1_diff), .s1_gain(s1_gain), .s2_valid(s2_valid),
    .s2_bipolar(s2_bipolar), .s2_prod(s2_prod)
  );

  adc_cal_output_stage #(
    .PROD_W(PROD_W), .DATA_W(DATA_W), .SHIFT(SHIFT), .ROUND_NEAREST(ROUND_NEAREST)
  ) u_out (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_bipolar(s2_bipolar),
    .s2_prod(s2_prod), .out_valid(out_valid), .out_code(out_code)
  );
endmodule

// File: rtl/adc_cal_core_chk.sv
module adc_cal_core_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_bipolar,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_code
);
  logic [2:0] vq;
  logic [2:0] mq;
  logic       rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      vq <= '0;
      mq <= '0;
    end else begin
      vq <= {vq[1:0], in_valid};
      mq <= {mq[1:0], in_bipolar};
    end
  end

  // R1: a reset edge leaves no result on the outputs
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R1: assert (out_valid == 1'b0);
    end
  end

  // R7: three register stages from accepted sample to result
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid == vq[2]);

  // R7: output code only moves together with a new result
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_code));

  // R4: doubled codes are even unless pinned at the top clamp
  assert_unipolar_even_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mq[2]) |-> (out_code[0] == 1'b0 || (&out_code)));
endmodule

bind adc_cal_core adc_cal_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bipolar(in_bipolar),
  .out_valid(out_valid), .out_code(out_code)
);

// File: tb/adc_cal_core_tb_top.sv
module adc_cal_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint MID = 64'sd8388608;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_bipolar = 1'b0;
  logic [23:0] in_sample = '0;
  logic        out_valid;
  logic [23:0] out_code;

  int     n_checks = 0;
  int     n_errors = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  longint m_off  = 64'h800000;
  longint m_gain = 64'h555555;

  logic [23:0] q_code[$];
  longint      q_due[$];
  string       q_tag[$];

  adc_cal_core dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_bipolar(in_bipolar),
    .in_sample(in_sample), .out_valid(out_valid), .out_code(out_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] model(longint x, longint off, longint gain, bit bip);
    longint d, p, s, v;
    d = x - (off - MID);
    p = d * gain;
    s = (p + 64'sd2097152) >>> 22;
    v = bip ? s + MID : s * 2;
    if (v < 0) v = 0;
    if (v > 64'sd16777215) v = 64'sd16777215;
    return v[23:0];
  endfunction

  task automatic check(string tag, bit ok, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_code.size() == 0) begin
        check("R7 unexpected result", 1'b0, out_code, 0);
      end else begin
        logic [23:0] e;
        longint      due;
        string       t;
        e = q_code.pop_front();
        due = q_due.pop_front();
        t = q_tag.pop_front();
        check(t, out_code == e, out_code, e);
        check({t, " R7 timing"}, cyc == due, cyc, due);
      end
    end
  end

  // present one sample at the coming negedge; expected uses current model coefs
  task automatic send(longint x, bit bip, string tag);
    @(negedge clk);
    in_valid   = 1'b1;
    in_bipolar = bip;
    in_sample  = x[23:0];
    q_code.push_back(model(x, m_off, m_gain, bip));
    q_due.push_back(cyc + 3);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we   = 1'b0;
    end
  endtask

  task automatic write_coef(bit sel, longint val);
    @(negedge clk);
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = sel;
    cfg_wdata = val[23:0];
    if (sel) m_gain = val; else m_off = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain(string tag);
    idle(6);
    check({tag, " drained"}, q_code.size() == 0, q_code.size(), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid == 1'b0, out_valid, 0);
    rst = 1'b0;
    idle(2);
    check("R1 out_valid after reset", out_valid == 1'b0, out_valid, 0);
    send(0, 1'b1, "R1 R5 default bipolar zero");
    send(3145728, 1'b0, "R1 R4 default unipolar");
    send(3145728, 1'b1, "R3 R5 default bipolar");
    drain("R1");
  endtask

  task automatic t_offset();
    write_coef(1'b1, 64'h400000);
    write_coef(1'b0, 64'h800010);
    send(100, 1'b0, "R2 positive offset unipolar");
    send(100, 1'b1, "R2 positive offset bipolar");
    write_coef(1'b0, 64'h7FFFF0);
    send(-16, 1'b1, "R2 negative offset");
    send(-20, 1'b0, "R2 negative offset unipolar");
    drain("R2");
  endtask

  task automatic t_round();
    write_coef(1'b0, 64'h800000);
    write_coef(1'b1, 64'h600000);
    send(1, 1'b1, "R3 half rounds up positive");
    send(-1, 1'b1, "R3 half rounds up negative");
    send(3, 1'b1, "R3 odd times 1.5");
    drain("R3");
  endtask

  task automatic t_clamp();
    write_coef(1'b1, 64'h555555);
    send(-1000, 1'b0, "R6 unipolar low clamp");
    send(8388607, 1'b0, "R6 unipolar high clamp");
    send(-8388608, 1'b1, "R6 bipolar low clamp");
    write_coef(1'b1, 64'hFFFFFF);
    send(8388607, 1'b1, "R6 bipolar high clamp");
    drain("R6");
  endtask

  task automatic t_stream();
    write_coef(1'b1, 64'h555555);
    write_coef(1'b0, 64'h800123);
    for (int i = 0; i < 8; i++) begin
      send(i * 400009 - 1500000, i[0], "R7 R9 back-to-back mixed modes");
    end
    drain("R7");
  endtask

  task automatic t_write_timing();
    write_coef(1'b0, 64'h800000);
    send(5000, 1'b1, "R7 sample before write");
    // coincident write and sample: this sample must use the old offset
    send(5000, 1'b1, "R8 sample with coincident write");
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 24'h800400;
    m_off = 64'h800400;
    send(5000, 1'b1, "R8 sample after write");
    cfg_we = 1'b0;
    send(5000, 1'b0, "R8 unipolar after write");
    drain("R8");
  endtask

  task automatic t_reset_mid();
    write_coef(1'b1, 64'h400000);
    write_coef(1'b0, 64'h900000);
    send(77777, 1'b1, "R1 dropped");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    q_code.delete(); q_due.delete(); q_tag.delete();
    m_off = 64'h800000;
    m_gain = 64'h555555;
    idle(2);
    rst = 1'b0;
    idle(4);
    check("R1 in-flight sample discarded", out_valid == 1'b0, out_valid, 0);
    send(77777, 1'b1, "R1 defaults after reset");
    send(-77777, 1'b0, "R1 defaults after reset unipolar");
    drain("R1 mid");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_offset();
    t_round();
    t_clamp();
    t_stream();
    t_write_timing();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule